// File: doc/BRIEF.md
# Lookup-Scaled Fixed-Point Multiplier

This block scales a stream of unsigned fixed-point samples by coefficients held in an internal lookup table. Each cycle it accepts a sample and a table address. The table has a two-cycle read, so the sample is held back by two registers and meets the coefficient fetched for the address that came with it. The product is registered and then cut back to the sample's own word length and fraction length. A configurable chain of output registers, which may be empty, follows.

The table contents come from a closed-form function of the address, so no initialisation file is needed. The coefficient word also leaves the block on its own port, so the table can be checked apart from the multiply. The default sample is 16 bits with 8 fraction bits. The default coefficient is 12 bits with 11 fraction bits, the table has 256 entries, and the output delay is four stages. A new operand pair can be accepted on every clock.

Top module: `lut_scale_pipe`

## Requirements
- R1: After a rising edge that is not in reset, `coef_o` holds the table word for the address captured one edge earlier. The table word for address A is (A*157 + 91) mod 2^CW. Address 0 is assumed right after reset.
- R2: `scaled_o` equals bits [CF+DW-1:CF] of the full product sample*word, where both operands were captured on the same edge. It appears after the (3+OUT_DLY)-th rising edge, counting the capturing edge as the first.
- R3: Product bits below position CF are discarded without rounding (floor). For example, sample 1 times any word below 2^CF gives 0.
- R4: Product bits above position CF+DW-1 are discarded, so an oversize result wraps modulo 2^DW.
- R5: With OUT_DLY set to 0, the trimmed product drives `scaled_o` directly, and the total latency is 3 edges.
- R6: While `rst_n` is low at a rising edge, every pipeline register clears, and both `scaled_o` and `coef_o` read 0.
- R7: A zero sample or a zero word gives a zero result.
- R8: When the word is at most 2^CF (a scale of 1.0 or less), the result never exceeds the sample.
- R9: Operand pairs captured on consecutive edges produce independent results on consecutive edges, with no stall or bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline registers |
| sample_i | input | DW | Unsigned fixed-point sample |
| addr_i | input | AW | Coefficient table address paired with `sample_i` |
| scaled_o | output | DW | Trimmed, delayed product in the sample's format |
| coef_o | output | CW | Raw table word, one edge after the address register |

## Verification
The hardest case to reach from the ports is the upper-bit wrap. A random pair rarely combines a near-full-scale sample with a coefficient above 1.0. The stimulus therefore searches the table for its largest word before the run. It then holds that address for a burst of near-maximum samples.

Two further phases drive the boundary cases on purpose:
- an all-zero sample burst;
- a burst of tiny samples that only flooring can zero.

A second instance with no output stages is driven by the same stimulus, so both delay variants are compared on every clock.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    localparam int unsigned TABLE_LAT = 2;
    localparam int unsigned MUL_LAT   = 1;
    localparam int unsigned COEF_MULT = 157;
    localparam int unsigned COEF_OFFS = 91;

    function automatic int unsigned coef_seed(int unsigned a);
        return a * COEF_MULT + COEF_OFFS;
    endfunction
endpackage

// File: rtl/lsp_coef_table.sv
module lsp_coef_table #(
    parameter int unsigned AW = 8,
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    output logic [CW-1:0] word_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [CW-1:0] entry_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign entry_w[i] = CW'(lsp_pkg::coef_seed(i));
    end

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] word;
        logic [1:0]    fill;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.addr = addr_i;
        st_d.word = entry_w[st_q.addr];
        st_d.fill = {st_q.fill[0], 1'b1};
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word_o = st_q.word;

    AST_TABLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill[1] |-> word_o == CW'(lsp_pkg::coef_seed(32'($past(addr_i, 2))))); // R1
endmodule

// File: rtl/lsp_delay.sv
module lsp_delay #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (DEPTH == 0) begin : g_wire
        logic unused_ok;
        assign unused_ok = ^{clk, rst_n};
        assign dout = din;
    end else begin : g_pipe
        logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                pipe_d[i] = pipe_q[i-1];
            end
            if (!rst_n) begin
                pipe_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            pipe_q <= pipe_d;
        end

        assign dout = pipe_q[DEPTH-1];
    end
endmodule

// File: rtl/lsp_mul_trim.sv
module lsp_mul_trim #(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 12,
    parameter int unsigned CF = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_i,
    input  logic [CW-1:0] b_i,
    output logic [DW-1:0] prod_o
);
    localparam int unsigned PW = DW + CW;

    typedef struct packed {
        logic [DW-1:0] prod;
        logic          warm;
    } mul_st_t;

    mul_st_t       st_d, st_q;
    logic [PW-1:0] full_w;

    always_comb begin
        full_w    = PW'(a_i) * PW'(b_i);
        st_d.prod = full_w[CF +: DW];
        st_d.warm = 1'b1;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign prod_o = st_q.prod;

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm && ($past(a_i) == '0 || $past(b_i) == '0)) |-> prod_o == '0); // R7
    AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm && ($past(b_i) <= CW'(1 << CF))) |-> prod_o <= $past(a_i)); // R8
endmodule

// File: rtl/lut_scale_pipe.sv
module lut_scale_pipe #(
    parameter int unsigned DW      = 16,
    parameter int unsigned AW      = 8,
    parameter int unsigned CW      = 12,
    parameter int unsigned CF      = 11,
    parameter int unsigned OUT_DLY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sample_i,
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] scaled_o,
    output logic [CW-1:0] coef_o
);
    logic [CW-1:0] word_w;
    logic [DW-1:0] aligned_w;
    logic [DW-1:0] trimmed_w;
    logic [1:0]    seen_d, seen_q;

    always_comb begin
        seen_d = {seen_q[0], 1'b1};
        if (!rst_n) begin
            seen_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        seen_q <= seen_d;
    end

    lsp_coef_table #(.AW(AW), .CW(CW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .word_o (word_w)
    );

    lsp_delay #(.W(DW), .DEPTH(lsp_pkg::TABLE_LAT)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sample_i),
        .dout  (aligned_w)
    );

    lsp_mul_trim #(.DW(DW), .CW(CW), .CF(CF)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (aligned_w),
        .b_i    (word_w),
        .prod_o (trimmed_w)
    );

    lsp_delay #(.W(DW), .DEPTH(OUT_DLY)) u_outdly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trimmed_w),
        .dout  (scaled_o)
    );

    assign coef_o = word_w;

    AST_OPERAND_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q[1] |-> aligned_w == $past(sample_i, 2)); // R2
endmodule

// File: tb/sim_lut_scale_pipe.sv
module sim_lut_scale_pipe;
    localparam int unsigned DW = 16;
    localparam int unsigned AW = 8;
    localparam int unsigned CW = 12;
    localparam int unsigned CF = 11;
    localparam int unsigned D0 = 4;
    localparam int unsigned N  = 1600;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [DW-1:0] sample;
    logic [AW-1:0] addr;
    logic [DW-1:0] s0, s1;
    logic [CW-1:0] c0, c1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int unsigned d_h [N];
    int unsigned a_h [N];

    lut_scale_pipe #(.DW(DW), .AW(AW), .CW(CW), .CF(CF), .OUT_DLY(D0)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .addr_i(addr),
        .scaled_o(s0), .coef_o(c0));

    lut_scale_pipe #(.DW(DW), .AW(AW), .CW(CW), .CF(CF), .OUT_DLY(0)) u1 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .addr_i(addr),
        .scaled_o(s1), .coef_o(c1));

    function automatic int unsigned ref_coef(int unsigned a);
        return (a * 157 + 91) % (1 << CW);
    endfunction

    function automatic int unsigned ref_scaled(int unsigned d, int unsigned a);
        longint unsigned p;
        p = longint'(d) * longint'(ref_coef(a));
        return int'((p >> CF) % (longint'(1) << DW));
    endfunction

    function automatic string phase_tag(int unsigned k);
        if (k < 20) return "R7 zero-sample";
        if (k < 40) return "R3 floor";
        if (k < 60) return "R4 wrap";
        if (k < 80) return "R8 unit-scale";
        return "R2 R9 random";
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned wrap_addr;
        int unsigned unit_addr;
        wrap_addr = 0;
        unit_addr = 0;
        for (int unsigned a = 0; a < (1 << AW); a++) begin
            if (ref_coef(a) > ref_coef(wrap_addr)) wrap_addr = a;
            if (ref_coef(a) <= (1 << CF) &&
                (ref_coef(unit_addr) > (1 << CF) || ref_coef(a) > ref_coef(unit_addr)))
                unit_addr = a;
        end

        rst_n  = 1'b0;
        sample = '0;
        addr   = '0;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            check("R6 reset coef u0", c0, 0);
            check("R6 reset scaled u0", s0, 0);
            check("R6 reset coef u1", c1, 0);
            check("R6 reset scaled u1", s1, 0);
        end

        for (int unsigned e = 0; e < N; e++) begin
            int unsigned d;
            int unsigned a;
            rst_n = 1'b1;
            if (e < 20) begin
                d = 0;
                a = $urandom % (1 << AW);
            end else if (e < 40) begin
                d = 1 + (e % 3);
                a = $urandom % (1 << AW);
            end else if (e < 60) begin
                d = (1 << DW) - 1 - (e % 4);
                a = wrap_addr;
            end else if (e < 80) begin
                d = $urandom % (1 << DW);
                a = unit_addr;
            end else begin
                d = $urandom % (1 << DW);
                a = $urandom % (1 << AW);
            end
            d_h[e] = d;
            a_h[e] = a;
            sample = DW'(d);
            addr   = AW'(a);
            @(posedge clk);
            @(negedge clk);

            // R1: word for the address captured one edge earlier
            check("R1 coef u0", c0, ref_coef(e == 0 ? 0 : a_h[e-1]));
            check("R1 coef u1", c1, ref_coef(e == 0 ? 0 : a_h[e-1]));

            if (e >= 2 + D0) begin
                int unsigned k;
                k = e - 2 - D0;
                check({phase_tag(k), " u0"}, s0, ref_scaled(d_h[k], a_h[k]));
                if (ref_coef(a_h[k]) <= (1 << CF)) begin
                    checks++;
                    if (s0 > d_h[k]) begin
                        fails++;
                        $display("FAIL R8 bound actual=%0h expected<=%0h", s0, d_h[k]);
                    end
                end
            end
            if (e >= 2) begin
                // R5: zero output stages gives three-edge latency
                check("R5 no-delay u1", s1, ref_scaled(d_h[e-2], a_h[e-2]));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule